// File: doc/BRIEF.md
# Sixteen-Channel Edge-Placed PWM Generator

This block produces sixteen pulse-width-modulated outputs from one shared time base. A prescaler divides the system clock into steps, and a step counter runs from zero up to a programmed period value before it wraps. Each channel holds two 8-bit positions on that counter. The output goes high when the counter reaches the first position and goes low when it reaches the second. The width of the pulse depends on the distance between the two positions. The order of the two positions sets the polarity.

Software programs the block through a 32-bit memory-mapped bus with an APB-like access: a write happens in any cycle where select, enable and write are all high. Read data is combinational from the address. Period and edge writes can be held in shadow copies. All shadow copies then move into the active registers together at a period wrap, so a retuned waveform never shows a half-updated period.

Top module: `pwm_edge_bank`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: A step lasts (prescale + 1) system clocks. A new prescale value (byte offset 0x00) takes effect only after the step in progress has finished.
- R3: The step counter counts 0, 1, … up to the period value (offset 0x04) and then wraps to 0, so one period lasts (period + 1) steps.
- R4: An enabled channel whose rising-edge value is 0 and falling-edge value is d (d not 0) is high for d steps of every period. Channel n has its rising-edge register at offset 0x10 + 8n and its falling-edge register at 0x14 + 8n. The output turns high one clock after the counter equals the rising-edge value and low one clock after it equals the falling-edge value.
- R5: Edges of (d, 0) give the inverted waveform, which is low for d steps of every period.
- R6: Bit k of the register at 0x08 enables channel k, and bit k of the register at 0x0C enables channel k+8. A channel whose enable bit is clear drives its output low.
- R7: A channel whose rising-edge and falling-edge values are equal stays low even when it is enabled.
- R8: While bit 0 of the register at 0xE4 is 1, writes to the period and edge registers leave the running waveform unchanged. The written values become active together at the next period wrap.
- R9: While bit 0 of the register at 0xE4 is 0, a write to the period or edge registers is active from the next clock.
- R10: Each register reads back its last written byte in bits 7..0, with bits 31..8 reading as zero. Unmapped or unaligned offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 8 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational from paddr_i |
| pwm_o | output | 16 | Channel outputs, bit n = channel n |

## Verification
The hardest state to reach is a staged update waiting in the shadow registers while the old waveform keeps running. Another is a prescale change that lands in the middle of a step. The bench sets the update bit and then rewrites an edge at an arbitrary point in the period. A reference model that counts clocks, steps and wraps on its own is compared against all sixteen outputs on every clock. Any early or late move from shadow to active therefore shows up as a mismatch on a specific cycle. Prescale changes are made mid-run so that the model and the design must agree on which step first uses the new length.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VAL_W = 8;
  localparam logic [AW-1:0] A_PRESC = 8'h00;
  localparam logic [AW-1:0] A_PER   = 8'h04;
  localparam logic [AW-1:0] A_EN_LO = 8'h08;
  localparam logic [AW-1:0] A_EN_HI = 8'h0C;
  localparam logic [AW-1:0] A_SYNC  = 8'hE4;
  localparam logic [AW-1:0] CH_BASE = 8'h10;
  localparam int unsigned CH_STRIDE = 8;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_edge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VAL_W-1:0] prescale_i,
  input  logic [VAL_W-1:0] period_i,
  output logic [VAL_W-1:0] step_o,
  output logic             wrap_o
);
  logic [VAL_W-1:0] pre_cnt_q, pre_lim_q, step_q;
  logic tick;

  assign tick   = (pre_cnt_q == pre_lim_q);
  // >= so a period shrunk below the counter still wraps at once
  assign wrap_o = tick && (step_q >= period_i);
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      pre_lim_q <= '0;
      step_q    <= '0;
    end else if (tick) begin
      pre_cnt_q <= '0;
      pre_lim_q <= prescale_i;
      step_q    <= wrap_o ? '0 : step_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  // R2
  presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(pre_lim_q));
  // R3
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> step_o == '0);
  // R3
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !wrap_o |=> step_o == $past(step_o) + 1'b1);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_edge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [VAL_W-1:0] rise_i,
  input  logic [VAL_W-1:0] fall_i,
  input  logic [VAL_W-1:0] step_i,
  output logic             out_o
);
  logic live;
  assign live = en_i && (rise_i != fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                out_o <= 1'b0;
    else if (!live)             out_o <= 1'b0;
    else if (step_i == rise_i)  out_o <= 1'b1;
    else if (step_i == fall_i)  out_o <= 1'b0;
  end

  // R6
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !out_o);
  // R7
  eq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i == fall_i |=> !out_o);
  // R4
  rise_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rise_i != fall_i && step_i == rise_i |=> out_o);
  // R5
  fall_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rise_i != fall_i && step_i == fall_i |=> !out_o);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_edge_pkg::*;
#(
  parameter int unsigned CH_N = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       psel_i,
  input  logic                       penable_i,
  input  logic                       pwrite_i,
  input  logic [AW-1:0]              paddr_i,
  input  logic [DATA_W-1:0]          pwdata_i,
  output logic [DATA_W-1:0]          prdata_o,
  input  logic                       wrap_i,
  output logic [VAL_W-1:0]           prescale_o,
  output logic [VAL_W-1:0]           period_o,
  output logic [CH_N-1:0]            en_o,
  output logic [CH_N-1:0][VAL_W-1:0] rise_o,
  output logic [CH_N-1:0][VAL_W-1:0] fall_o
);
  localparam int unsigned IDX_W = $clog2(CH_N);
  localparam logic [AW-1:0] CH_SPAN = AW'(CH_N * CH_STRIDE);

  logic [VAL_W-1:0] presc_q, per_sh_q, per_act_q, en_lo_q, en_hi_q, sync_q;
  logic [CH_N-1:0][VAL_W-1:0] rise_sh_q, fall_sh_q, rise_act_q, fall_act_q;
  logic [VAL_W-1:0] wd;
  logic [AW-1:0] ch_off;
  logic [IDX_W-1:0] idx;
  logic wr, ch_hit, is_fall, staged;
  logic unused_hi;

  assign wd        = pwdata_i[VAL_W-1:0];
  assign unused_hi = ^pwdata_i[DATA_W-1:VAL_W];
  assign wr      = psel_i && penable_i && pwrite_i;
  assign ch_off  = paddr_i - CH_BASE;
  assign ch_hit  = (paddr_i >= CH_BASE) && (ch_off < CH_SPAN) && (paddr_i[1:0] == 2'b00);
  assign idx     = ch_off[3 +: IDX_W];
  assign is_fall = paddr_i[2];
  assign staged  = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q    <= '0;
      per_sh_q   <= '0;
      per_act_q  <= '0;
      en_lo_q    <= '0;
      en_hi_q    <= '0;
      sync_q     <= '0;
      rise_sh_q  <= '0;
      fall_sh_q  <= '0;
      rise_act_q <= '0;
      fall_act_q <= '0;
    end else begin
      // shadows equal actives when not staged, so the copy is harmless then
      if (wrap_i) begin
        per_act_q  <= per_sh_q;
        rise_act_q <= rise_sh_q;
        fall_act_q <= fall_sh_q;
      end
      if (wr) begin
        case (paddr_i)
          A_PRESC: presc_q <= wd;
          A_PER: begin
            per_sh_q <= wd;
            if (!staged) per_act_q <= wd;
          end
          A_EN_LO: en_lo_q <= wd;
          A_EN_HI: en_hi_q <= wd;
          A_SYNC:  sync_q  <= wd;
          default: begin
            if (ch_hit && is_fall) begin
              fall_sh_q[idx] <= wd;
              if (!staged) fall_act_q[idx] <= wd;
            end else if (ch_hit) begin
              rise_sh_q[idx] <= wd;
              if (!staged) rise_act_q[idx] <= wd;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      A_PRESC: prdata_o[VAL_W-1:0] = presc_q;
      A_PER:   prdata_o[VAL_W-1:0] = per_sh_q;
      A_EN_LO: prdata_o[VAL_W-1:0] = en_lo_q;
      A_EN_HI: prdata_o[VAL_W-1:0] = en_hi_q;
      A_SYNC:  prdata_o[VAL_W-1:0] = sync_q;
      default:
        if (ch_hit) prdata_o[VAL_W-1:0] = is_fall ? fall_sh_q[idx] : rise_sh_q[idx];
    endcase
  end

  assign prescale_o = presc_q;
  assign period_o   = per_act_q;
  assign en_o       = CH_N'({en_hi_q, en_lo_q});
  assign rise_o     = rise_act_q;
  assign fall_o     = fall_act_q;

  // R8
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    staged && !wrap_i |=> $stable(period_o) && $stable(rise_o) && $stable(fall_o));
  // R9
  direct_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && paddr_i == A_PER && !staged |=> period_o == $past(wd));
endmodule

// File: rtl/pwm_edge_bank.sv
module pwm_edge_bank
  import pwm_edge_pkg::*;
#(
  parameter int unsigned CH_N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [AW-1:0]     paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic [CH_N-1:0]   pwm_o
);
  logic [VAL_W-1:0] prescale, period, step;
  logic wrap;
  logic [CH_N-1:0] en;
  logic [CH_N-1:0][VAL_W-1:0] rise, fall;

  pwm_regs #(.CH_N(CH_N)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .wrap_i(wrap), .prescale_o(prescale), .period_o(period),
    .en_o(en), .rise_o(rise), .fall_o(fall)
  );

  pwm_timebase u_tb (
    .clk_i, .rst_ni, .prescale_i(prescale), .period_i(period),
    .step_o(step), .wrap_o(wrap)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_chan u_ch (
      .clk_i, .rst_ni, .en_i(en[c]), .rise_i(rise[c]), .fall_i(fall[c]),
      .step_i(step), .out_o(pwm_o[c])
    );
  end

  // R1
  rst_low_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> pwm_o == '0);
endmodule

// File: tb/sim_pwm_edge_bank.sv
module sim_pwm_edge_bank;
  localparam int CLK_P = 10;
  localparam int NCH = 16;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic [NCH-1:0] pwm;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  pwm_edge_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pwm_o(pwm)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  int m_pc, m_pl, m_step, m_presc, m_per_sh, m_per, m_sync;
  int m_rise_sh[NCH], m_fall_sh[NCH], m_rise[NCH], m_fall[NCH];
  bit [15:0] m_en;
  bit [NCH-1:0] m_out;

  task automatic m_reset();
    m_pc = 0; m_pl = 0; m_step = 0; m_presc = 0; m_per_sh = 0; m_per = 0; m_sync = 0;
    m_en = 0; m_out = 0;
    for (int i = 0; i < NCH; i++) begin
      m_rise_sh[i] = 0; m_fall_sh[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
    end
  endtask

  always @(posedge clk) begin
    bit tick, wrap, w;
    int a, d, ch;
    bit [NCH-1:0] nxt;
    if (!rst_n) m_reset();
    else begin
      w = psel && penable && pwrite;
      a = paddr; d = pwdata[7:0];
      tick = (m_pc == m_pl);
      wrap = tick && (m_step >= m_per);
      for (int i = 0; i < NCH; i++) begin
        if (!m_en[i] || m_rise[i] == m_fall[i]) nxt[i] = 0;
        else if (m_step == m_rise[i]) nxt[i] = 1;
        else if (m_step == m_fall[i]) nxt[i] = 0;
        else nxt[i] = m_out[i];
      end
      m_out = nxt;
      if (tick) begin
        m_pc = 0; m_pl = m_presc;
        m_step = wrap ? 0 : (m_step + 1) % 256;
      end else m_pc++;
      if (wrap) begin
        m_per = m_per_sh;
        for (int i = 0; i < NCH; i++) begin m_rise[i] = m_rise_sh[i]; m_fall[i] = m_fall_sh[i]; end
      end
      if (w) begin
        if (a == 'h00) m_presc = d;
        else if (a == 'h04) begin m_per_sh = d; if (!m_sync[0]) m_per = d; end
        else if (a == 'h08) m_en[7:0] = d[7:0];
        else if (a == 'h0C) m_en[15:8] = d[7:0];
        else if (a == 'hE4) m_sync = d;
        else if (a >= 'h10 && a < 'h10 + 8*NCH && a % 4 == 0) begin
          ch = (a - 'h10) / 8;
          if (a % 8 == 4) begin m_fall_sh[ch] = d; if (!m_sync[0]) m_fall[ch] = d; end
          else begin m_rise_sh[ch] = d; if (!m_sync[0]) m_rise[ch] = d; end
        end
      end
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      checks++;
      if (pwm !== m_out) begin
        fails++;
        $display("FAIL %s: pwm=%h expected=%h at %0t", phase, pwm, m_out, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); psel = 1; penable = 1; pwrite = 0; paddr = a;
    #1;
    checks++;
    if (prdata !== exp) begin
      fails++;
      $display("FAIL %s: read %h = %h expected %h", req, a, prdata, exp);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic high_chk(input int ch, input int nclk, input int exp, input string req);
    int cnt = 0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      if (pwm[ch]) cnt++;
    end
    checks++;
    if (cnt != exp) begin
      fails++;
      $display("FAIL %s: ch%0d high clocks %0d expected %0d", req, ch, cnt, exp);
    end
  endtask

  task automatic settle(input int nclk);
    repeat (nclk) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (pwm !== '0) begin fails++; $display("FAIL R1: pwm=%h expected 0 in reset", pwm); end
    rst_n = 1;
    // R1: register reset values
    rd_chk(8'h00, 0, "R1"); rd_chk(8'h04, 0, "R1"); rd_chk(8'h08, 0, "R1");
    rd_chk(8'h0C, 0, "R1"); rd_chk(8'hE4, 0, "R1"); rd_chk(8'h8C, 0, "R1");

    // R4/R3: normal order, prescale 0, period 9
    phase = "R4";
    wr(8'h04, 9); wr(8'h10, 0); wr(8'h14, 3); wr(8'h08, 8'h01);
    settle(30);
    high_chk(0, 10, 3, "R4");
    // R5: inverted order on ch1
    phase = "R5";
    wr(8'h18, 3); wr(8'h1C, 0); wr(8'h08, 8'h03);
    settle(30);
    high_chk(1, 10, 7, "R5");
    high_chk(0, 10, 3, "R3");
    // R2: prescale values, changed mid-run
    phase = "R2";
    wr(8'h00, 2); settle(70);
    high_chk(0, 30, 9, "R2");
    wr(8'h00, 4); settle(110);
    high_chk(0, 50, 15, "R2");
    high_chk(1, 50, 35, "R2");
    // R6: high enable group (ch9), low group bit1 cleared
    phase = "R6";
    wr(8'h58, 0); wr(8'h5C, 5); wr(8'h0C, 8'h02); wr(8'h08, 8'h01);
    settle(110);
    high_chk(9, 50, 25, "R6");
    high_chk(1, 50, 0, "R6");
    rd_chk(8'h0C, 32'h02, "R6");
    // R7: equal edges
    phase = "R7";
    wr(8'h20, 4); wr(8'h24, 4); wr(8'h08, 8'h05);
    settle(110);
    high_chk(2, 50, 0, "R7");
    // R8: staged update held until wrap
    phase = "R8";
    wr(8'h00, 0); settle(20);
    wr(8'hE4, 1);
    settle(4);
    wr(8'h14, 6); wr(8'h04, 11);
    rd_chk(8'h14, 6, "R10");
    settle(40);
    high_chk(0, 12, 6, "R8");
    // R9: direct mode
    phase = "R9";
    wr(8'hE4, 0);
    wr(8'h14, 2);
    settle(30);
    high_chk(0, 12, 2, "R9");
    // R10: readback width, unmapped and unaligned accesses
    phase = "R10";
    wr(8'h04, 32'hFFFF_FF09);
    rd_chk(8'h04, 32'h09, "R10");
    wr(8'hF0, 32'h77); rd_chk(8'hF0, 0, "R10");
    wr(8'h11, 32'h55); rd_chk(8'h10, 0, "R10"); rd_chk(8'h11, 0, "R10");
    rd_chk(8'h90, 0, "R10");
    settle(30);
    high_chk(0, 10, 2, "R10");
    finish_run();
  end
endmodule